// File: doc/BRIEF.md
# Host Bus Byte-Lane Steering Unit

This unit sits between a host data bus and a 32-bit internal data path that serves both control/status registers and the transmit and receive data and status FIFO ports. It decides which host byte lands in which internal byte lane. Four inputs drive that decision: a static bus-width strap that selects 32-bit or 16-bit operation, a programmable word-swap control bit, an endian-select input, and the host address line A1.

In 32-bit operation every host access maps to exactly one internal word. In 16-bit operation two half-word accesses make up one internal word. On a write, the access with A1=0 parks its half-word in a holding register. The access with A1=1 completes the word and commits it. On a read, the access with A1=0 fetches the internal word and latches it. The access with A1=1 returns the other half from that latch, so both halves come from the same word.

The two steering stages run in opposite orders. A write goes through word swap first and endian ordering second. A read goes through endian ordering first and word swap second. The word-swap control bit is itself written through this same steering path, which is why its set value is a pattern that every steering combination leaves unchanged.

Top module: `hbus_lane_steer`

## Requirements
- R1: During and after reset, `int_wr_vld` is 0, the word-swap control bit is 0, and the write holding register is 0.
- R2: A 32-bit write (`strap_bus32`=1, `host_cfg_sel`=0) drives `int_wr_vld` high for exactly one cycle on the clock edge that follows the access. `int_wdata` carries host_wdata[31:16] as the high half and host_wdata[15:0] as the low half.
- R3: With `endian_rev`=1, the endian stage reverses the internal byte order 3-2-1-0, where byte 3 is bits [31:24] and byte 0 is bits [7:0]. Byte 3 swaps with byte 0 and byte 2 swaps with byte 1. With `endian_rev`=0, data passes through the stage unchanged.
- R4: In 32-bit operation the word-swap bit has no effect on either writes or reads.
- R5: In 16-bit operation, a write with A1=0 stores host_wdata[15:0] in the holding register and does not assert `int_wr_vld`. A write with A1=1 commits {current half, held half} when the swap bit is 0. The holding register is still 0 if no A1=0 write has occurred since reset.
- R6: In 16-bit operation with the swap bit set, the committed word is {held half, current half}.
- R7: On a 16-bit write, the endian reversal is applied to the assembled 32-bit word after the swap stage.
- R8: A 32-bit read asserts `int_rd_req` in the same cycle. `host_rdata` is then the endian-staged `int_rdata`.
- R9: A 16-bit read with A1=0 asserts `int_rd_req` and latches the endian-staged word. It returns the low half of that word when the swap bit is 0 and the high half when it is 1, on host_rdata[15:0], with host_rdata[31:16] = 0.
- R10: A 16-bit read with A1=1 does not assert `int_rd_req` and ignores `int_rdata`. It returns the other half of the latched word.
- R11: A committed write with `host_cfg_sel`=1 goes to the swap bit, not to the internal write port. The bit becomes 1 only if the steered word is all ones; any other word clears it. A read with `host_cfg_sel`=1 returns 32 copies of the bit and does not assert `int_rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_bus32 | input | 1 | Static width strap: 1 = 32-bit host bus, 0 = 16-bit |
| endian_rev | input | 1 | 1 = reverse byte order within the 32-bit word |
| host_a1 | input | 1 | Host address bit A1 (half-word select in 16-bit mode) |
| host_cfg_sel | input | 1 | Access targets the word-swap control bit |
| host_wr_vld | input | 1 | Host write access this cycle |
| host_wdata | input | 32 | Host write data (bits [15:0] only in 16-bit mode) |
| host_rd_vld | input | 1 | Host read access this cycle |
| host_rdata | output | 32 | Host read data, combinational during the read access |
| int_wr_vld | output | 1 | Internal write strobe (registered) |
| int_wdata | output | 32 | Internal write word (registered) |
| int_rd_req | output | 1 | Internal read fetch, same cycle as the host read |
| int_rdata | input | 32 | Internal read word, valid while `int_rd_req` is high |

## Verification
Two functions can act in the same cycle. One is the registered commit of a finished 16-bit write on the internal write port. The other is the first half of a new 16-bit read, which drives a fetch and fills the read latch. The bench provokes this overlap by running a two-access write directly into a two-access read with no idle cycle between them. It then judges each side separately: the committed word must be exactly the assembled write, and the read halves must come from the newly fetched word and not from the write's holding register. A second pairing follows a swap-bit change made through a configuration write. The very next half-word accesses must already use the new swap setting.

// File: rtl/hls_pkg.sv
package hls_pkg;
   typedef enum logic {
      BUS_W16 = 1'b0,
      BUS_W32 = 1'b1
   } bus_w_e;
endpackage

// File: rtl/hls_byte_rev.sv
module hls_byte_rev #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   localparam int W     = BYTE_W * LANES
) (
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (LANES < 2) begin : g_bad_lanes
      $error("hls_byte_rev: LANES must be at least 2");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign q[i*BYTE_W +: BYTE_W] = en ? d[(LANES-1-i)*BYTE_W +: BYTE_W]
                                        : d[i*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/hls_wr_path.sv
module hls_wr_path
   import hls_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   localparam int W     = BYTE_W * LANES,
   localparam int HW    = W / 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  bus_w_e       bus_mode,
   input  logic         swap_eff,
   input  logic         endn,
   input  logic         a1,
   input  logic         cfg,
   input  logic         wr_vld,
   input  logic [W-1:0] wdata,
   output logic         cfg_commit,
   output logic [W-1:0] steered,
   output logic         int_wr_vld_o,
   output logic [W-1:0] int_wdata_o
);
   logic [HW-1:0] hold_q;
   logic [W-1:0]  assembled;
   logic [W-1:0]  swapped;
   logic          commit;
   logic          park;

   assign park   = wr_vld && (bus_mode == BUS_W16) && !a1;
   assign commit = wr_vld && ((bus_mode == BUS_W32) || a1);

   always_comb begin
      assembled = swap_eff ? {hold_q, wdata[HW-1:0]} : {wdata[HW-1:0], hold_q};
      swapped   = (bus_mode == BUS_W32) ? wdata : assembled;
   end

   hls_byte_rev #(.BYTE_W(BYTE_W), .LANES(LANES)) u_wr_rev (
      .en (endn),
      .d  (swapped),
      .q  (steered)
   );

   assign cfg_commit = commit && cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q       <= '0;
         int_wr_vld_o <= 1'b0;
         int_wdata_o  <= '0;
      end else begin
         if (park) hold_q <= wdata[HW-1:0];
         int_wr_vld_o <= commit && !cfg;
         if (commit && !cfg) int_wdata_o <= steered;
      end
   end

   assert_half_parks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      park |=> !int_wr_vld_o);
   assert_full_commits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && (bus_mode == BUS_W32) && !cfg) |=> int_wr_vld_o);
   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int_wr_vld_o && !(wr_vld && !cfg)) |=> !int_wr_vld_o);
endmodule

// File: rtl/hls_rd_path.sv
module hls_rd_path
   import hls_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   localparam int W     = BYTE_W * LANES,
   localparam int HW    = W / 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  bus_w_e       bus_mode,
   input  logic         swap_eff,
   input  logic         endn,
   input  logic         a1,
   input  logic         rd_vld,
   input  logic [W-1:0] src_word,
   output logic         fetch,
   output logic [W-1:0] host_rdata
);
   logic [W-1:0]  ordered;
   logic [W-1:0]  latch_q;
   logic [W-1:0]  pick_src;
   logic          pick_hi;
   logic [HW-1:0] half;

   hls_byte_rev #(.BYTE_W(BYTE_W), .LANES(LANES)) u_rd_rev (
      .en (endn),
      .d  (src_word),
      .q  (ordered)
   );

   assign fetch = rd_vld && ((bus_mode == BUS_W32) || !a1);

   always_comb begin
      pick_src = a1 ? latch_q : ordered;
      pick_hi  = a1 ^ swap_eff;
      half     = pick_hi ? pick_src[W-1:HW] : pick_src[HW-1:0];
      if (!rd_vld)                    host_rdata = '0;
      else if (bus_mode == BUS_W32)   host_rdata = ordered;
      else                            host_rdata = {{HW{1'b0}}, half};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       latch_q <= '0;
      else if (rd_vld && (bus_mode == BUS_W16) && !a1)  latch_q <= ordered;
   end

   assert_second_half_local_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld && (bus_mode == BUS_W16) && a1) |-> !fetch);
   assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld && (bus_mode == BUS_W16)) |-> (host_rdata[W-1:HW] == '0));
   assert_first_half_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld && !a1) |-> fetch);
endmodule

// File: rtl/hbus_lane_steer.sv
module hbus_lane_steer
   import hls_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   localparam int W     = BYTE_W * LANES
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strap_bus32,
   input  logic         endian_rev,
   input  logic         host_a1,
   input  logic         host_cfg_sel,
   input  logic         host_wr_vld,
   input  logic [W-1:0] host_wdata,
   input  logic         host_rd_vld,
   output logic [W-1:0] host_rdata,
   output logic         int_wr_vld,
   output logic [W-1:0] int_wdata,
   output logic         int_rd_req,
   input  logic [W-1:0] int_rdata
);
   if ((LANES % 2) != 0 || LANES < 2) begin : g_bad_lanes
      $error("hbus_lane_steer: LANES must be even and at least 2");
   end

   bus_w_e       bus_mode;
   logic         swap_q;
   logic         swap_eff;
   logic         cfg_commit;
   logic [W-1:0] steered;
   logic [W-1:0] src_word;
   logic         fetch;

   assign bus_mode = strap_bus32 ? BUS_W32 : BUS_W16;
   assign swap_eff = swap_q && (bus_mode == BUS_W16);
   assign src_word = host_cfg_sel ? {W{swap_q}} : int_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          swap_q <= 1'b0;
      else if (cfg_commit) swap_q <= &steered;
   end

   hls_wr_path #(.BYTE_W(BYTE_W), .LANES(LANES)) u_wr (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_mode     (bus_mode),
      .swap_eff     (swap_eff),
      .endn         (endian_rev),
      .a1           (host_a1),
      .cfg          (host_cfg_sel),
      .wr_vld       (host_wr_vld),
      .wdata        (host_wdata),
      .cfg_commit   (cfg_commit),
      .steered      (steered),
      .int_wr_vld_o (int_wr_vld),
      .int_wdata_o  (int_wdata)
   );

   hls_rd_path #(.BYTE_W(BYTE_W), .LANES(LANES)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_mode   (bus_mode),
      .swap_eff   (swap_eff),
      .endn       (endian_rev),
      .a1         (host_a1),
      .rd_vld     (host_rd_vld),
      .src_word   (src_word),
      .fetch      (fetch),
      .host_rdata (host_rdata)
   );

   assign int_rd_req = fetch && !host_cfg_sel;

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> !int_wr_vld);
   assert_cfg_no_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_vld && host_cfg_sel) |=> !int_wr_vld);
   assert_cfg_no_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_vld && host_cfg_sel) |-> !int_rd_req);
   assert_no_idle_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd_vld |-> !int_rd_req);
endmodule

// File: tb/hbus_lane_steer_bench.sv
module hbus_lane_steer_bench;
   typedef struct packed {
      logic [3:0]  req;
      logic        b32;
      logic        en;
      logic        a1;
      logic        cfg;
      logic        wr;
      logic        rd;
      logic [31:0] wd;
      logic [31:0] ird;
      logic [31:0] erd;
      logic        ereq;
      logic        ewv;
      logic [31:0] ewd;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VEC [NV] = '{
      '{4'd2,  1,0,0,0,1,0, 32'h11223344, 32'h0,        32'h0,        0,1, 32'h11223344}, // R2
      '{4'd3,  1,1,0,0,1,0, 32'h11223344, 32'h0,        32'h0,        0,1, 32'h44332211}, // R3
      '{4'd8,  1,0,0,0,0,1, 32'h0,        32'hA1B2C3D4, 32'hA1B2C3D4, 1,0, 32'h0},        // R8
      '{4'd3,  1,1,0,0,0,1, 32'h0,        32'hA1B2C3D4, 32'hD4C3B2A1, 1,0, 32'h0},        // R3
      '{4'd5,  0,0,0,0,1,0, 32'h9999BEEF, 32'h0,        32'h0,        0,0, 32'h0},        // R5
      '{4'd5,  0,0,1,0,1,0, 32'h0000CAFE, 32'h0,        32'h0,        0,1, 32'hCAFEBEEF}, // R5
      '{4'd7,  0,1,0,0,1,0, 32'h00001234, 32'h0,        32'h0,        0,0, 32'h0},        // R7
      '{4'd7,  0,1,1,0,1,0, 32'h00005678, 32'h0,        32'h0,        0,1, 32'h34127856}, // R7
      '{4'd9,  0,0,0,0,0,1, 32'h0,        32'h89ABCDEF, 32'h0000CDEF, 1,0, 32'h0},        // R9
      '{4'd10, 0,0,1,0,0,1, 32'h0,        32'h0,        32'h000089AB, 0,0, 32'h0},        // R10
      '{4'd9,  0,1,0,0,0,1, 32'h0,        32'h89ABCDEF, 32'h0000AB89, 1,0, 32'h0},        // R9
      '{4'd10, 0,1,1,0,0,1, 32'h0,        32'h0,        32'h0000EFCD, 0,0, 32'h0},        // R10
      '{4'd11, 1,0,0,1,1,0, 32'hFFFFFFFF, 32'h0,        32'h0,        0,0, 32'h0},        // R11
      '{4'd11, 1,0,0,1,0,1, 32'h0,        32'h0,        32'hFFFFFFFF, 0,0, 32'h0},        // R11
      '{4'd6,  0,0,0,0,1,0, 32'h00001111, 32'h0,        32'h0,        0,0, 32'h0},        // R6
      '{4'd6,  0,0,1,0,1,0, 32'h00002222, 32'h0,        32'h0,        0,1, 32'h11112222}, // R6
      '{4'd9,  0,0,0,0,0,1, 32'h0,        32'h89ABCDEF, 32'h000089AB, 1,0, 32'h0},        // R9
      '{4'd10, 0,0,1,0,0,1, 32'h0,        32'h0,        32'h0000CDEF, 0,0, 32'h0},        // R10
      '{4'd4,  1,0,0,0,1,0, 32'h11223344, 32'h0,        32'h0,        0,1, 32'h11223344}, // R4
      '{4'd4,  1,0,0,0,0,1, 32'h0,        32'hA1B2C3D4, 32'hA1B2C3D4, 1,0, 32'h0},        // R4
      '{4'd11, 0,0,0,1,1,0, 32'h0,        32'h0,        32'h0,        0,0, 32'h0},        // R11
      '{4'd11, 0,0,1,1,1,0, 32'h0,        32'h0,        32'h0,        0,0, 32'h0},        // R11
      '{4'd11, 0,0,0,1,0,1, 32'h0,        32'hFFFFFFFF, 32'h0,        0,0, 32'h0},        // R11
      '{4'd11, 0,0,1,1,0,1, 32'h0,        32'hFFFFFFFF, 32'h0,        0,0, 32'h0},        // R11
      '{4'd5,  0,0,0,0,1,0, 32'h0000AAAA, 32'h0,        32'h0,        0,0, 32'h0},        // R5
      '{4'd5,  0,0,1,0,1,0, 32'h00005555, 32'h0,        32'h0,        0,1, 32'h5555AAAA}, // R5
      '{4'd9,  0,0,0,0,0,1, 32'h0,        32'h01020304, 32'h00000304, 1,0, 32'h0},        // R9
      '{4'd10, 0,0,1,0,0,1, 32'h0,        32'hDEADBEEF, 32'h00000102, 0,0, 32'h0}         // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_bus32 = 1'b1;
   logic        endian_rev = 1'b0;
   logic        host_a1 = 1'b0;
   logic        host_cfg_sel = 1'b0;
   logic        host_wr_vld = 1'b0;
   logic [31:0] host_wdata = '0;
   logic        host_rd_vld = 1'b0;
   logic [31:0] host_rdata;
   logic        int_wr_vld;
   logic [31:0] int_wdata;
   logic        int_rd_req;
   logic [31:0] int_rdata = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   hbus_lane_steer u_hbus_lane_steer (
      .clk          (clk),
      .rst_n        (rst_n),
      .strap_bus32  (strap_bus32),
      .endian_rev   (endian_rev),
      .host_a1      (host_a1),
      .host_cfg_sel (host_cfg_sel),
      .host_wr_vld  (host_wr_vld),
      .host_wdata   (host_wdata),
      .host_rd_vld  (host_rd_vld),
      .host_rdata   (host_rdata),
      .int_wr_vld   (int_wr_vld),
      .int_wdata    (int_wdata),
      .int_rd_req   (int_rd_req),
      .int_rdata    (int_rdata)
   );

   task automatic chk(input logic [3:0] req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      strap_bus32  = v.b32;
      endian_rev   = v.en;
      host_a1      = v.a1;
      host_cfg_sel = v.cfg;
      host_wr_vld  = v.wr;
      host_rd_vld  = v.rd;
      host_wdata   = v.wd;
      int_rdata    = v.ird;
      #1;
      if (v.rd) chk(v.req, "host_rdata", host_rdata, v.erd);
      chk(v.req, "int_rd_req", {31'b0, int_rd_req}, {31'b0, v.ereq});
      @(posedge clk);
      #1;
      chk(v.req, "int_wr_vld", {31'b0, int_wr_vld}, {31'b0, v.ewv});
      if (v.ewv) chk(v.req, "int_wdata", int_wdata, v.ewd);
   endtask

   task automatic idle();
      @(negedge clk);
      host_wr_vld  = 1'b0;
      host_rd_vld  = 1'b0;
      host_cfg_sel = 1'b0;
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state while reset is held
      chk(4'd1, "int_wr_vld in reset", {31'b0, int_wr_vld}, 32'h0);
      rst_n = 1'b1;
      // R1: swap bit reads back 0 after reset
      apply('{4'd1, 1,0,0,1,0,1, 32'h0, 32'hFFFFFFFF, 32'h0, 0,0, 32'h0});

      for (int i = 0; i < NV; i++) apply(VEC[i]);
      idle();

      // R11: a non-all-ones configuration word clears the swap bit
      apply('{4'd11, 1,0,0,1,1,0, 32'hFFFFFFFF, 32'h0, 32'h0, 0,0, 32'h0});
      apply('{4'd11, 1,0,0,1,1,0, 32'h0000FFFF, 32'h0, 32'h0, 0,0, 32'h0});
      apply('{4'd11, 1,0,0,1,0,1, 32'h0, 32'h0, 32'h0, 0,0, 32'h0});

      // R1: set swap, hold a half, then reset mid-run
      apply('{4'd1, 1,0,0,1,1,0, 32'hFFFFFFFF, 32'h0, 32'h0, 0,0, 32'h0});
      apply('{4'd1, 0,0,0,0,1,0, 32'h00003333, 32'h0, 32'h0, 0,0, 32'h0});
      idle();
      rst_n = 1'b0;
      @(negedge clk);
      chk(4'd1, "int_wr_vld in reset", {31'b0, int_wr_vld}, 32'h0);
      rst_n = 1'b1;
      apply('{4'd1, 1,0,0,1,0,1, 32'h0, 32'h0, 32'h0, 0,0, 32'h0});
      // R5: lone A1=1 write after reset pairs with a zero held half
      apply('{4'd5, 0,0,1,0,1,0, 32'h00007777, 32'h0, 32'h0, 0,1, 32'h77770000});
      idle();
      @(negedge clk);
      chk(4'd2, "int_wr_vld after idle", {31'b0, int_wr_vld}, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule